// File: doc/BRIEF.md
# Pitched Rectangle Copy Command Splitter

This block takes a single copy request and breaks it into a stream of commands for a memory-to-memory transfer engine. In rectangle mode the request describes two pitched surfaces (base offset, pitch, bytes per pixel) and a source and destination rectangle of equal size. The block computes the starting byte offsets, splits the height into chunks of at most `MAX_LINES` lines, and issues one copy command per chunk, moving both offsets forward by pitch times lines after each one.

In linear mode the request is a byte count. The block copies whole pages of `2**PAGE_SHIFT` bytes as lines of one page each. Any remainder smaller than a page goes out as one final single-line command. Every copy command is followed by two fence sub-commands: a no-op, then an offset-out that carries zero data. Both the request side and the command side use a valid/ready handshake. A one-cycle done pulse marks the end of each request. A request whose rectangle is malformed is rejected with a one-cycle error pulse.

Top module: `rect_copy_splitter`

## Requirements
- R1: In rectangle mode, a request is rejected when either pitch is zero, or when the source and destination widths differ (x1-x0), or when their heights differ (y1-y0). A rejected request produces an `err` pulse in the cycle after acceptance, no command and no `done` pulse.
- R2: The first copy command's source offset is src_base + src_y0*src_pitch + src_x0*bpp. The destination offset is computed the same way from the destination fields. The command also carries both pitches unchanged.
- R3: In rectangle mode, the line length of every copy command is (x1-x0)*bpp.
- R4: Each copy command carries min(remaining height, MAX_LINES) lines, which is never 0. Commands continue until the remaining height is zero. A zero-height request issues no command.
- R5: After each rectangle chunk, the source offset advances by src_pitch*lines and the destination offset by dst_pitch*lines.
- R6: Opcodes are 0 for copy, 1 for no-op and 2 for offset-out. Every copy is followed directly by a no-op and then an offset-out. All data fields of the fence sub-commands are zero.
- R7: In linear mode, size>>PAGE_SHIFT pages are sent as commands in which both pitches and the line length equal the page size, with at most MAX_LINES lines each. Both offsets start at the bases and advance by lines<<PAGE_SHIFT. Pitch, bpp and rectangle inputs have no effect, and a zero pitch does not cause a rejection.
- R8: In linear mode, a nonzero remainder (size mod page size) produces one last command in which both pitches and the line length equal the remainder, with a line count of 1. No such command is issued when the remainder is zero.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command outputs hold their values. A new command appears only after the current one has been accepted.
- R10: `done` pulses for one cycle in the cycle after the last offset-out of a request is accepted. If a request issues no command, `done` pulses in the cycle after the request is accepted. `req_ready` is high again in that same cycle.
- R11: `req_ready` is high after reset and whenever the block is idle. It is low from the cycle after a productive request is accepted until that request's `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_linear | input | 1 | 1: linear byte copy, 0: rectangle copy |
| req_size | input | AW | Byte count (linear mode) |
| req_src_base | input | AW | Source base offset |
| req_dst_base | input | AW | Destination base offset |
| req_src_pitch | input | AW | Source bytes per row |
| req_dst_pitch | input | AW | Destination bytes per row |
| req_bpp | input | PW | Bytes per pixel |
| req_src_x0 | input | CW | Source left |
| req_src_y0 | input | CW | Source top |
| req_src_x1 | input | CW | Source right (exclusive) |
| req_src_y1 | input | CW | Source bottom (exclusive) |
| req_dst_x0 | input | CW | Destination left |
| req_dst_y0 | input | CW | Destination top |
| req_dst_x1 | input | CW | Destination right (exclusive) |
| req_dst_y1 | input | CW | Destination bottom (exclusive) |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 2 | 0 copy, 1 no-op, 2 offset-out |
| cmd_src_off | output | AW | Source offset |
| cmd_dst_off | output | AW | Destination offset |
| cmd_src_pitch | output | AW | Source pitch |
| cmd_dst_pitch | output | AW | Destination pitch |
| cmd_line_len | output | AW | Bytes per line |
| cmd_lines | output | LW | Line count |
| done | output | 1 | Request finished pulse |
| err | output | 1 | Request rejected pulse |

## Verification
Two events can fall in the same cycle. The `done` pulse for one request coincides with `req_ready` reopening, and the next request can be accepted in that same cycle. The bench keeps `req_valid` asserted back-to-back, so each new request is taken exactly in the done cycle. Meanwhile `cmd_ready` follows a pseudo-random pattern that stalls the command stream at arbitrary points. The bench queues the expected commands in order, with done and error markers between them. It requires `done` in exactly the cycle after the final offset-out is accepted, and the new request's first copy must carry freshly computed offsets rather than the advanced offsets left over from the previous request.

// File: rtl/rect_copy_splitter.sv
module rect_copy_splitter #(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int PW         = 4,
  parameter int MAX_LINES  = 2047,
  parameter int PAGE_SHIFT = 12,
  localparam int LW        = $clog2(MAX_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_linear,
  input  logic [AW-1:0] req_size,
  input  logic [AW-1:0] req_src_base,
  input  logic [AW-1:0] req_dst_base,
  input  logic [AW-1:0] req_src_pitch,
  input  logic [AW-1:0] req_dst_pitch,
  input  logic [PW-1:0] req_bpp,
  input  logic [CW-1:0] req_src_x0,
  input  logic [CW-1:0] req_src_y0,
  input  logic [CW-1:0] req_src_x1,
  input  logic [CW-1:0] req_src_y1,
  input  logic [CW-1:0] req_dst_x0,
  input  logic [CW-1:0] req_dst_y0,
  input  logic [CW-1:0] req_dst_x1,
  input  logic [CW-1:0] req_dst_y1,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [AW-1:0] cmd_src_off,
  output logic [AW-1:0] cmd_dst_off,
  output logic [AW-1:0] cmd_src_pitch,
  output logic [AW-1:0] cmd_dst_pitch,
  output logic [AW-1:0] cmd_line_len,
  output logic [LW-1:0] cmd_lines,
  output logic          done,
  output logic          err
);
  localparam logic [1:0] OP_COPY = 2'd0;
  localparam logic [1:0] OP_NOP  = 2'd1;
  localparam logic [1:0] OP_OUT  = 2'd2;
  localparam logic [AW-1:0] PAGE = {{(AW-1){1'b0}}, 1'b1} << PAGE_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_COPY, S_NOP, S_OUT} state_t;

  state_t               st;
  logic [AW-1:0]        soff, doff, sp, dp, len, left;
  logic [PAGE_SHIFT-1:0] tail;
  logic                 done_q, err_q;

  logic          req_fire, cmd_fire, copy_st, in_tail, more, rect_bad, has_work;
  logic [LW-1:0] chunk;
  logic [AW-1:0] tail_w, s_start, d_start, len_start, left_start;
  logic [CW-1:0] s_w, s_h, d_w, d_h;

  assign s_w = req_src_x1 - req_src_x0;
  assign s_h = req_src_y1 - req_src_y0;
  assign d_w = req_dst_x1 - req_dst_x0;
  assign d_h = req_dst_y1 - req_dst_y0;

  assign req_ready = (st == S_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign cmd_valid = (st != S_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign copy_st   = (st == S_COPY);
  assign in_tail   = (left == '0);
  assign more      = (left != '0) || (tail != '0);
  assign tail_w    = AW'(tail);
  assign chunk     = (left > AW'(MAX_LINES)) ? LW'(MAX_LINES) : left[LW-1:0];

  assign rect_bad = (req_src_pitch == '0) || (req_dst_pitch == '0) ||
                    (s_w != d_w) || (s_h != d_h);

  assign s_start = req_linear ? req_src_base :
                   req_src_base + AW'(req_src_y0) * req_src_pitch + AW'(req_src_x0) * AW'(req_bpp);
  assign d_start = req_linear ? req_dst_base :
                   req_dst_base + AW'(req_dst_y0) * req_dst_pitch + AW'(req_dst_x0) * AW'(req_bpp);
  assign len_start  = req_linear ? PAGE : AW'(s_w) * AW'(req_bpp);
  assign left_start = req_linear ? (req_size >> PAGE_SHIFT) : AW'(s_h);
  assign has_work   = req_linear ? (req_size != '0) : (s_h != '0);

  assign cmd_op = (st == S_NOP) ? OP_NOP : (st == S_OUT) ? OP_OUT : OP_COPY;
  assign cmd_src_off   = copy_st ? soff : '0;
  assign cmd_dst_off   = copy_st ? doff : '0;
  assign cmd_src_pitch = copy_st ? (in_tail ? tail_w : sp) : '0;
  assign cmd_dst_pitch = copy_st ? (in_tail ? tail_w : dp) : '0;
  assign cmd_line_len  = copy_st ? (in_tail ? tail_w : len) : '0;
  assign cmd_lines     = copy_st ? (in_tail ? LW'(1) : chunk) : '0;
  assign done = done_q;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      soff   <= '0;
      doff   <= '0;
      sp     <= '0;
      dp     <= '0;
      len    <= '0;
      left   <= '0;
      tail   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        S_IDLE: if (req_fire) begin
          if (!req_linear && rect_bad) begin
            err_q <= 1'b1;
          end else begin
            soff <= s_start;
            doff <= d_start;
            sp   <= req_linear ? PAGE : req_src_pitch;
            dp   <= req_linear ? PAGE : req_dst_pitch;
            len  <= len_start;
            left <= left_start;
            tail <= req_linear ? req_size[PAGE_SHIFT-1:0] : '0;
            if (has_work) st <= S_COPY;
            else done_q <= 1'b1;
          end
        end
        S_COPY: if (cmd_fire) begin
          if (!in_tail) begin
            left <= left - AW'(chunk);
            soff <= soff + sp * AW'(chunk);
            doff <= doff + dp * AW'(chunk);
          end else begin
            tail <= '0;
          end
          st <= S_NOP;
        end
        S_NOP: if (cmd_fire) st <= S_OUT;
        S_OUT: if (cmd_fire) begin
          if (more) st <= S_COPY;
          else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_src_off) &&
      $stable(cmd_dst_off) && $stable(cmd_src_pitch) && $stable(cmd_dst_pitch) &&
      $stable(cmd_line_len) && $stable(cmd_lines));

  // R6
  copy_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_op == OP_COPY |=> cmd_valid && cmd_op == OP_NOP);

  // R6
  nop_then_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_op == OP_NOP |=> cmd_valid && cmd_op == OP_OUT);

  // R6
  fence_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op != OP_COPY |-> cmd_src_off == '0 && cmd_dst_off == '0 &&
      cmd_src_pitch == '0 && cmd_dst_pitch == '0 && cmd_line_len == '0 && cmd_lines == '0);

  // R4
  lines_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_COPY |-> cmd_lines != '0 && cmd_lines <= LW'(MAX_LINES));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !cmd_valid);

  // R1
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_valid && !done);
endmodule

// File: tb/rect_copy_splitter_bench.sv
module rect_copy_splitter_bench;
  localparam int AW = 24, CW = 8, PW = 4, ML = 3, PS = 4, LW = 2;
  localparam int PG = 1 << PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_linear = 1'b0;
  logic [AW-1:0] req_size = '0, req_src_base = '0, req_dst_base = '0;
  logic [AW-1:0] req_src_pitch = '0, req_dst_pitch = '0;
  logic [PW-1:0] req_bpp = '0;
  logic [CW-1:0] sx0 = '0, sy0 = '0, sx1 = '0, sy1 = '0, dx0 = '0, dy0 = '0, dx1 = '0, dy1 = '0;
  logic cmd_valid, cmd_ready = 1'b0, done, err;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_src_off, cmd_dst_off, cmd_src_pitch, cmd_dst_pitch, cmd_line_len;
  logic [LW-1:0] cmd_lines;

  always #2.5 clk = ~clk;

  rect_copy_splitter #(.AW(AW), .CW(CW), .PW(PW), .MAX_LINES(ML), .PAGE_SHIFT(PS)) u_rect_copy_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_linear(req_linear), .req_size(req_size), .req_src_base(req_src_base),
    .req_dst_base(req_dst_base), .req_src_pitch(req_src_pitch), .req_dst_pitch(req_dst_pitch),
    .req_bpp(req_bpp), .req_src_x0(sx0), .req_src_y0(sy0), .req_src_x1(sx1), .req_src_y1(sy1),
    .req_dst_x0(dx0), .req_dst_y0(dy0), .req_dst_x1(dx1), .req_dst_y1(dy1),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_src_off(cmd_src_off), .cmd_dst_off(cmd_dst_off), .cmd_src_pitch(cmd_src_pitch),
    .cmd_dst_pitch(cmd_dst_pitch), .cmd_line_len(cmd_line_len), .cmd_lines(cmd_lines),
    .done(done), .err(err));

  typedef struct packed {
    logic [1:0] kind;   // 0 command, 1 done marker, 2 error marker
    logic [1:0] op;
    logic [AW-1:0] so, dof, sp, dp, ln;
    logic [LW-1:0] lines;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int checks = 0, errors = 0;
  logic pend_done = 1'b0;
  logic held = 1'b0;
  logic [2+5*AW+LW-1:0] held_val = '0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] kind, input logic [1:0] op, input int so, input int dof,
                      input int sp, input int dp, input int ln, input int lines, input string tag);
    exp_t e;
    e.kind = kind; e.op = op; e.so = AW'(so); e.dof = AW'(dof); e.sp = AW'(sp);
    e.dp = AW'(dp); e.ln = AW'(ln); e.lines = LW'(lines);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic fences();
    push(2'd0, 2'd1, 0, 0, 0, 0, 0, 0, "R6");
    push(2'd0, 2'd2, 0, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic wait_accept();
    int n = 0;
    req_valid = 1'b1;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk(1'b0, "R11", "watchdog request", 0, 1);
    @(negedge clk);
  endtask

  task automatic send_rect(input int sb, input int db, input int sp, input int dp, input int bpp,
                           input int ax0, input int ay0, input int ax1, input int ay1,
                           input int bx0, input int by0, input int bx1, input int by1);
    int so, dof, h, l, w;
    req_linear = 1'b0; req_size = AW'(12345);
    req_src_base = AW'(sb); req_dst_base = AW'(db);
    req_src_pitch = AW'(sp); req_dst_pitch = AW'(dp); req_bpp = PW'(bpp);
    sx0 = CW'(ax0); sy0 = CW'(ay0); sx1 = CW'(ax1); sy1 = CW'(ay1);
    dx0 = CW'(bx0); dy0 = CW'(by0); dx1 = CW'(bx1); dy1 = CW'(by1);
    if (sp == 0 || dp == 0 || (ax1 - ax0) != (bx1 - bx0) || (ay1 - ay0) != (by1 - by0)) begin
      push(2'd2, 2'd0, 0, 0, 0, 0, 0, 0, "R1");
    end else begin
      so = sb + ay0 * sp + ax0 * bpp;
      dof = db + by0 * dp + bx0 * bpp;
      w = ax1 - ax0;
      h = ay1 - ay0;
      while (h > 0) begin
        l = (h > ML) ? ML : h;
        push(2'd0, 2'd0, so, dof, sp, dp, w * bpp, l, "R2 R3 R4 R5");
        fences();
        h -= l; so += sp * l; dof += dp * l;
      end
      push(2'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R10");
    end
    wait_accept();
  endtask

  task automatic send_lin(input int sb, input int db, input int size);
    int so, dof, pages, rem, l;
    req_linear = 1'b1; req_size = AW'(size);
    req_src_base = AW'(sb); req_dst_base = AW'(db);
    req_src_pitch = '0; req_dst_pitch = AW'(7); req_bpp = PW'(3);
    sx0 = 8'd1; sy0 = 8'd2; sx1 = 8'd9; sy1 = 8'd3; dx0 = 8'd0; dy0 = 8'd0; dx1 = 8'd1; dy1 = 8'd5;
    so = sb; dof = db;
    pages = size >> PS; rem = size % PG;
    while (pages > 0) begin
      l = (pages > ML) ? ML : pages;
      push(2'd0, 2'd0, so, dof, PG, PG, PG, l, "R7");
      fences();
      pages -= l; so += l * PG; dof += l * PG;
    end
    if (rem != 0) begin
      push(2'd0, 2'd0, so, dof, rem, rem, rem, 1, "R8");
      fences();
    end
    push(2'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R10");
    wait_accept();
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = lfsr[0] | lfsr[3];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_done) chk(done == 1'b1, "R10", "done after last offset-out", longint'(done), 1);
      if (done || err) begin
        if (expq.size() == 0) chk(1'b0, "R10", "unexpected done/err", longint'({done, err}), 0);
        else begin
          chk(expq[0].kind == (done ? 2'd1 : 2'd2), tagq[0], "done/err marker kind",
              longint'(done ? 1 : 2), longint'(expq[0].kind));
          void'(expq.pop_front()); void'(tagq.pop_front());
        end
      end
      pend_done = 1'b0;
      chk(!(cmd_valid && req_ready), "R11", "ready while busy", longint'(req_ready), 0);
      if (held)
        chk(cmd_valid && held_val == {cmd_op, cmd_src_off, cmd_dst_off, cmd_src_pitch, cmd_dst_pitch, cmd_line_len, cmd_lines},
            "R9", "held command changed", longint'(cmd_valid), 1);
      held = cmd_valid && !cmd_ready;
      held_val = {cmd_op, cmd_src_off, cmd_dst_off, cmd_src_pitch, cmd_dst_pitch, cmd_line_len, cmd_lines};
      if (cmd_valid && cmd_ready) begin
        if (expq.size() == 0 || expq[0].kind != 2'd0)
          chk(1'b0, "R1", "unexpected command", longint'(cmd_op), -1);
        else begin
          chk(cmd_op == expq[0].op, tagq[0], "opcode", longint'(cmd_op), longint'(expq[0].op));
          chk(cmd_src_off == expq[0].so, tagq[0], "src offset", longint'(cmd_src_off), longint'(expq[0].so));
          chk(cmd_dst_off == expq[0].dof, tagq[0], "dst offset", longint'(cmd_dst_off), longint'(expq[0].dof));
          chk(cmd_src_pitch == expq[0].sp, tagq[0], "src pitch", longint'(cmd_src_pitch), longint'(expq[0].sp));
          chk(cmd_dst_pitch == expq[0].dp, tagq[0], "dst pitch", longint'(cmd_dst_pitch), longint'(expq[0].dp));
          chk(cmd_line_len == expq[0].ln, tagq[0], "line length", longint'(cmd_line_len), longint'(expq[0].ln));
          chk(cmd_lines == expq[0].lines, tagq[0], "lines", longint'(cmd_lines), longint'(expq[0].lines));
          void'(expq.pop_front()); void'(tagq.pop_front());
          if (cmd_op == 2'd2 && expq.size() != 0 && expq[0].kind == 2'd1) pend_done = 1'b1;
        end
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset ready", longint'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R9", "reset cmd_valid", longint'(cmd_valid), 0);
    chk(done == 1'b0 && err == 1'b0, "R10", "reset pulses", longint'({done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int h = 0; h < 8; h++)
      for (int w = 1; w < 4; w++)
        for (int b = 0; b < 3; b++)
          send_rect(100 * h, 1024, 32, 48, 1 << b, w, h % 3, w + w, h % 3 + h, 2, 1, 2 + w, 1 + h);
    send_rect(0, 0, 0, 48, 2, 0, 0, 2, 2, 0, 0, 2, 2);
    send_rect(0, 0, 32, 0, 2, 0, 0, 2, 2, 0, 0, 2, 2);
    send_rect(0, 0, 32, 48, 2, 0, 0, 3, 2, 0, 0, 2, 2);
    send_rect(0, 0, 32, 48, 2, 0, 0, 2, 4, 0, 0, 2, 2);
    send_rect(8, 16, 32, 48, 4, 1, 1, 3, 8, 0, 2, 2, 9);
    for (int s = 0; s < 72; s++) send_lin(s * 3, 2048 + s, s);
    send_lin(5, 6, 10 * PG + 9);
    req_valid = 1'b0;
    n = 0;
    while (expq.size() != 0 && n < 20000) begin @(negedge clk); n++; end
    if (expq.size() != 0) chk(1'b0, "R10", "watchdog drain", longint'(expq.size()), 0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule